// File: doc/BRIEF.md
# Two-Level Carry Lookahead Adder

This block adds two unsigned operands and an incoming carry in a single combinational pass. It produces the sum and the outgoing carry. The operands are split into equal slices. Each slice works out per-bit generate and propagate terms, forms its own internal carries as flat sum-of-products expressions, and reports one generate and one propagate term for the whole slice.

A second lookahead unit of the same form takes the slice terms and the incoming carry. From them it forms the carry into every slice except the lowest one. Carries therefore never pass bit by bit or slice by slice. The longest path is a fixed number of gate levels for any data pattern.

The block also drives the generate and propagate terms of the whole word. A wider adder can then place several of these blocks under a further lookahead level. The operand width and the slice size are parameters, with defaults of 16 and 4. Elaboration stops if the width is not a whole multiple of the slice size.

Top module: `cla_two_level_adder`

## Requirements
- R1: `sum` equals the low 16 bits of `op_a + op_b + carry_in`, with all values taken as unsigned.
- R2: `carry_out` equals bit 16 of `op_a + op_b + carry_in`.
- R3: `blk_prop` is 1 exactly when `op_a ^ op_b` is all ones, that is, when every bit position has one operand bit set.
- R4: `blk_gen` is 1 exactly when `op_a + op_b`, without the incoming carry, is 2^16 or more.
- R5: `carry_out` equals `blk_gen | (blk_prop & carry_in)`. When `blk_prop` is 1, `sum` is all zeros if `carry_in` is 1 and all ones if `carry_in` is 0.
- R6: `blk_gen` and `blk_prop` are never 1 at the same time.
- R7: An incoming carry that crosses every slice is handled correctly. Examples: 0xFFFF + 0x0000 + 1 gives sum 0x0000 with carry_out 1, and 0xFFFF + 0xFFFF + 1 gives sum 0xFFFF with carry_out 1.
- R8: With both operands and `carry_in` at zero, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 16 | First unsigned operand |
| op_b | input | 16 | Second unsigned operand |
| carry_in | input | 1 | Incoming carry into bit 0 |
| sum | output | 16 | Low bits of the total |
| carry_out | output | 1 | Carry out of the top bit |
| blk_gen | output | 1 | Whole-word generate term, for cascading |
| blk_prop | output | 1 | Whole-word propagate term, for cascading |

## Verification
The hardest case to reach from the ports is a carry that enters at bit 0 and must travel through every slice. This happens only when all sixteen bit positions propagate, which uniform random operands almost never produce. The stimulus builds the second operand as the complement of the first and then flips a few sparse bits. This gives full-length and nearly full-length propagate runs that stop at different slice boundaries. Directed vectors add the all-ones, all-zeros and alternating patterns, and these are combined with fully random pairs.

// File: rtl/cla_pkg.sv
package cla_pkg;
   localparam int unsigned CLA_DEF_WIDTH = 16;
   localparam int unsigned CLA_DEF_GROUP = 4;

   function automatic bit cla_shape_ok(input int unsigned width, input int unsigned group);
      return (group >= 2) && (width >= group) && ((width % group) == 0);
   endfunction
endpackage

// File: rtl/cla_unit.sv
module cla_unit #(
   parameter int unsigned N = 4
) (
   input  logic [N-1:0] gen_i,
   input  logic [N-1:0] prop_i,
   input  logic         cin_i,
   output logic [N-1:0] carry_o,
   output logic         grp_gen_o,
   output logic         grp_prop_o
);
   // carry_o[k] is the carry into position k; carry_o[0] is the incoming carry.
   always_comb begin
      carry_o[0] = cin_i;
      for (int k = 1; k < N; k++) begin
         logic acc;
         logic run;
         acc = 1'b0;
         for (int j = 0; j < k; j++) begin
            logic term;
            term = gen_i[j];
            for (int m = 0; m < N; m++) begin
               if (m > j && m < k) term = term & prop_i[m];
            end
            acc = acc | term;
         end
         run = cin_i;
         for (int m = 0; m < k; m++) run = run & prop_i[m];
         carry_o[k] = acc | run;
      end
   end

   always_comb begin
      grp_gen_o = 1'b0;
      for (int j = 0; j < N; j++) begin
         logic term;
         term = gen_i[j];
         for (int m = 0; m < N; m++) begin
            if (m > j) term = term & prop_i[m];
         end
         grp_gen_o = grp_gen_o | term;
      end
      grp_prop_o = &prop_i;
   end
endmodule

// File: rtl/cla_group.sv
module cla_group #(
   parameter int unsigned GROUP = 4
) (
   input  logic [GROUP-1:0] a_i,
   input  logic [GROUP-1:0] b_i,
   input  logic             cin_i,
   output logic [GROUP-1:0] sum_o,
   output logic             gg_o,
   output logic             gp_o
);
   logic [GROUP-1:0] bit_gen;
   logic [GROUP-1:0] bit_prop;
   logic [GROUP-1:0] bit_carry;

   assign bit_gen  = a_i & b_i;
   assign bit_prop = a_i ^ b_i;

   cla_unit #(.N(GROUP)) look_i (
      .gen_i      (bit_gen),
      .prop_i     (bit_prop),
      .cin_i      (cin_i),
      .carry_o    (bit_carry),
      .grp_gen_o  (gg_o),
      .grp_prop_o (gp_o)
   );

   assign sum_o = bit_prop ^ bit_carry;
endmodule

// File: rtl/cla_two_level_adder.sv
module cla_two_level_adder #(
   parameter int unsigned WIDTH = cla_pkg::CLA_DEF_WIDTH,
   parameter int unsigned GROUP = cla_pkg::CLA_DEF_GROUP
) (
   input  logic [WIDTH-1:0] op_a,
   input  logic [WIDTH-1:0] op_b,
   input  logic             carry_in,
   output logic [WIDTH-1:0] sum,
   output logic             carry_out,
   output logic             blk_gen,
   output logic             blk_prop
);
   localparam int unsigned NG = WIDTH / GROUP;

   if (!cla_pkg::cla_shape_ok(WIDTH, GROUP)) begin : g_bad_shape
      $error("cla_two_level_adder: WIDTH must be a multiple of GROUP, GROUP >= 2");
   end

   logic [NG-1:0] slice_gen;
   logic [NG-1:0] slice_prop;
   logic [NG-1:0] slice_cin;

   for (genvar g = 0; g < NG; g++) begin : g_slice
      cla_group #(.GROUP(GROUP)) grp_i (
         .a_i   (op_a[g*GROUP +: GROUP]),
         .b_i   (op_b[g*GROUP +: GROUP]),
         .cin_i (slice_cin[g]),
         .sum_o (sum[g*GROUP +: GROUP]),
         .gg_o  (slice_gen[g]),
         .gp_o  (slice_prop[g])
      );
   end

   cla_unit #(.N(NG)) top_look_i (
      .gen_i      (slice_gen),
      .prop_i     (slice_prop),
      .cin_i      (carry_in),
      .carry_o    (slice_cin),
      .grp_gen_o  (blk_gen),
      .grp_prop_o (blk_prop)
   );

   assign carry_out = blk_gen | (blk_prop & carry_in);
endmodule

// File: rtl/cla_adder_checker.sv
module cla_adder_checker #(
   parameter int unsigned WIDTH = cla_pkg::CLA_DEF_WIDTH
) (
   input logic [WIDTH-1:0] op_a,
   input logic [WIDTH-1:0] op_b,
   input logic             carry_in,
   input logic [WIDTH-1:0] sum,
   input logic             carry_out,
   input logic             blk_gen,
   input logic             blk_prop
);
   logic [WIDTH:0] total;
   logic           known;

   always_comb begin
      total = {1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in};
      known = !$isunknown({op_a, op_b, carry_in, sum, carry_out, blk_gen, blk_prop});
   end

   always @(*) begin
      if (known) begin
         a_r1_sum_value: assert (sum == total[WIDTH-1:0]);
         a_r2_carry_value: assert (carry_out == total[WIDTH]);
         a_r5_prop_passes_cin: assert (!blk_prop || (carry_out == carry_in && sum == {WIDTH{!carry_in}}));
         a_r5_gen_forces_cout: assert (!blk_gen || carry_out);
         a_r6_gen_prop_apart: assert (!(blk_gen && blk_prop));
      end
   end
endmodule

bind cla_two_level_adder cla_adder_checker #(.WIDTH(WIDTH)) chk_i (
   .op_a      (op_a),
   .op_b      (op_b),
   .carry_in  (carry_in),
   .sum       (sum),
   .carry_out (carry_out),
   .blk_gen   (blk_gen),
   .blk_prop  (blk_prop)
);

// File: tb/cla_two_level_adder_tb_top.sv
module cla_two_level_adder_tb_top;
   logic        clk = 1'b0;
   logic [15:0] op_a = '0;
   logic [15:0] op_b = '0;
   logic        carry_in = 1'b0;
   logic [15:0] sum;
   logic        carry_out;
   logic        blk_gen;
   logic        blk_prop;
   int          checks = 0;
   int          failures = 0;
   bit          done = 1'b0;

   always #10 clk = ~clk;

   cla_two_level_adder dut_i (
      .op_a(op_a), .op_b(op_b), .carry_in(carry_in),
      .sum(sum), .carry_out(carry_out), .blk_gen(blk_gen), .blk_prop(blk_prop)
   );

   function automatic logic [16:0] exp_total(input logic [15:0] a, input logic [15:0] b, input logic c);
      return {1'b0, a} + {1'b0, b} + {16'd0, c};
   endfunction
   function automatic logic exp_gen(input logic [15:0] a, input logic [15:0] b);
      logic [16:0] t;
      t = {1'b0, a} + {1'b0, b};
      return t[16];
   endfunction
   function automatic logic exp_prop(input logic [15:0] a, input logic [15:0] b);
      return (a ^ b) == 16'hFFFF;
   endfunction

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s a=%h b=%h cin=%b actual=%h expected=%h", req, op_a, op_b, carry_in, got, exp);
      end
   endtask

   task automatic apply(input logic [15:0] a, input logic [15:0] b, input logic c);
      logic [16:0] t;
      @(negedge clk);
      op_a = a; op_b = b; carry_in = c;
      #2;
      t = exp_total(a, b, c);
      check("R1", {16'd0, sum}, {16'd0, t[15:0]});
      check("R2", {31'd0, carry_out}, {31'd0, t[16]});
      check("R3", {31'd0, blk_prop}, {31'd0, exp_prop(a, b)});
      check("R4", {31'd0, blk_gen}, {31'd0, exp_gen(a, b)});
      check("R5", {31'd0, carry_out}, {31'd0, exp_gen(a, b) | (exp_prop(a, b) & c)});
      check("R6", {31'd0, blk_gen & blk_prop}, 32'd0);
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      int unsigned seed_set;
      seed_set = $urandom(32'd20240611);
      // R8: all zeros
      @(negedge clk);
      #2;
      check("R8", {15'd0, sum, carry_out}, 32'd0);
      check("R8", {30'd0, blk_gen, blk_prop}, 32'd0);
      apply(16'h0000, 16'h0000, 1'b0);
      // R7: carry crossing every slice
      apply(16'hFFFF, 16'h0000, 1'b1);
      check("R7", {15'd0, carry_out, sum}, {15'd0, 1'b1, 16'h0000});
      apply(16'hFFFF, 16'hFFFF, 1'b1);
      check("R7", {15'd0, carry_out, sum}, {15'd0, 1'b1, 16'hFFFF});
      apply(16'h0000, 16'hFFFF, 1'b0);
      apply(16'h5555, 16'hAAAA, 1'b0);
      apply(16'h5555, 16'hAAAA, 1'b1);
      apply(16'h000F, 16'h0001, 1'b0);
      apply(16'h0FFF, 16'h0001, 1'b0);
      apply(16'h00FF, 16'h0000, 1'b1);
      apply(16'h8000, 16'h8000, 1'b0);
      // long propagate runs broken at sparse positions
      for (int i = 0; i < 600; i++) begin
         logic [15:0] a;
         logic [15:0] flip;
         a = 16'($urandom);
         flip = (i % 3 == 0) ? 16'd0 : (16'd1 << ($urandom % 16));
         apply(a, ~a ^ flip, 1'($urandom));
      end
      // fully random pairs
      for (int i = 0; i < 1500; i++) begin
         apply(16'($urandom), 16'($urandom), 1'($urandom));
      end
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule